// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Engine

This block is the bus-facing receive side of a serial EEPROM slave on an I2C two-wire bus. It synchronises SCL and SDA to the system clock and detects START and STOP conditions. It shifts in the device-select byte, then the word-address byte, then any number of data bytes, and pulls SDA low to acknowledge each byte it accepts. Every accepted data byte leaves the block as a one-cycle write strobe with its array address, so a page buffer can collect it.

When the master sends STOP after at least one data byte, the block pulses a programming-start strobe. It then holds `busy` high for a parameterised number of clock cycles, which models the nonvolatile write time. While `busy` is high the block ignores the bus entirely, including its own address. A master can therefore poll with START plus a write address: it gets no acknowledge until programming is done. Data bytes step only the low page bits of the address pointer, so a long burst wraps inside its page.

Top module: `eeprom_wr_slave`

## Requirements
- R1: A device-select byte whose top four bits are 1010 and whose bit 0 (R/W) is 0 is acknowledged. Its bits 3..1 become address bits 10..8 of the array pointer.
- R2: A device-select byte with any other top nibble, or with R/W equal to 1, is not acknowledged. No later byte of that transfer is acknowledged or written.
- R3: After an accepted device select, the next byte is acknowledged and loads address bits 7..0 of the pointer.
- R4: Each byte after the word address is acknowledged and produces a single-cycle `wr_en` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to the byte (MSB received first).
- R5: After each data byte, pointer bits 3..0 increase by one modulo 16, and bits 10..4 stay unchanged.
- R6: A STOP that follows at least one data byte in the same transfer gives a one-cycle `prog_start` pulse. `busy` rises in that same cycle and stays high for exactly PROG_CYCLES clock cycles.
- R7: A STOP with no complete data byte since the last START starts no programming, and `busy` stays low.
- R8: While `busy` is high, the block never drives SDA and never pulses `wr_en`, so a START plus a valid write address gets no acknowledge.
- R9: Once `busy` has fallen, a START plus a valid write address is acknowledged again.
- R10: After reset, `sda_oe`, `wr_en`, `prog_start` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| wr_en | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | ADDR_BITS | Array address for the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| prog_start | output | 1 | One-cycle strobe that starts internal programming |
| busy | output | 1 | High while the programming cycle runs |

## Verification
The bench runs a single-byte write, a 20-byte burst that crosses the page boundary, and a sweep of all eight block-select values. These show whether the pointer takes its upper bits from the select byte and wraps only its low bits. It polls immediately after STOP and again after `busy` falls, which separates a slave that ignores the bus while busy from one that only suppresses writes. Transfers with a wrong device code, with a read bit, or ending in STOP before any data byte show that a rejected or empty transfer leaves no write and starts no programming.

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave #(
  parameter int ADDR_BITS = 11,
  parameter int PAGE_BITS = 4,
  parameter int PROG_CYCLES = 1000,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  output logic                 wr_en,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [7:0]           wr_data,
  output logic                 prog_start,
  output logic                 busy
);
  localparam int HB = ADDR_BITS - 8;
  localparam int CW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_DEV, S_WADDR, S_DATA} st_t;

  st_t                  st;
  logic [2:0]           scl_q, sda_q;
  logic [7:0]           sh;
  logic [3:0]           bits;
  logic [ADDR_BITS-1:0] ptr;
  logic                 got;
  logic [CW-1:0]        cnt;

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sh <= '0;
      bits <= '0;
      ptr <= '0;
      got <= 1'b0;
      cnt <= '0;
      sda_oe <= 1'b0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      prog_start <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      prog_start <= 1'b0;
      if (busy) cnt <= cnt - 1'b1;
      if (busy) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
        got <= 1'b0;
      end else if (start_c) begin
        st <= S_DEV;
        bits <= '0;
        sda_oe <= 1'b0;
        got <= 1'b0;
      end else if (stop_c) begin
        if (got && st != S_IDLE) begin
          cnt <= CW'(PROG_CYCLES);
          prog_start <= 1'b1;
        end
        st <= S_IDLE;
        got <= 1'b0;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise && bits < 4'd8) begin
          sh <= {sh[6:0], sda_s};
          bits <= bits + 4'd1;
        end else if (scl_fall && bits == 4'd8) begin
          if (sda_oe) begin
            sda_oe <= 1'b0;
            bits <= '0;
            st <= (st == S_DEV) ? S_WADDR : S_DATA;
          end else begin
            case (st)
              S_DEV: begin
                if (sh[7:4] == DEV_ID && !sh[0]) begin
                  sda_oe <= 1'b1;
                  ptr[ADDR_BITS-1:8] <= sh[HB:1];
                end else begin
                  st <= S_IDLE;
                end
              end
              S_WADDR: begin
                sda_oe <= 1'b1;
                ptr[7:0] <= sh;
              end
              default: begin
                sda_oe <= 1'b1;
                wr_en <= 1'b1;
                wr_addr <= ptr;
                wr_data <= sh;
                ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
                got <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_wr_slave_chk.sv
module eeprom_wr_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic wr_en,
  input logic prog_start,
  input logic busy
);
  // R8
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_oe);
  // R8
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !wr_en);
  // R6
  prog_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) prog_start |-> busy);
  // R6
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> prog_start);
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en);
endmodule

bind eeprom_wr_slave eeprom_wr_slave_chk u_chk (.*);

// File: tb/tb_eeprom_wr_slave.sv
module tb_eeprom_wr_slave;
  localparam int PROG = 300;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_en, prog_start, busy;
  logic [10:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  eeprom_wr_slave #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_start(prog_start), .busy(busy));

  int checks = 0, fails = 0;
  int nlog = 0, nprog = 0, busy_cyc = 0;
  logic [10:0] la [64];
  logic [7:0]  ld [64];
  bit done = 0;

  always @(negedge clk) begin
    if (wr_en && nlog < 64) begin
      la[nlog] = wr_addr;
      ld[nlog] = wr_data;
      nlog++;
    end
    if (prog_start) nprog++;
    if (busy) busy_cyc++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl = 1; wt(H);
    sda_m = 0; wt(H);
    scl = 0; wt(2);
  endtask

  task automatic bus_stop();
    sda_m = 0; wt(H);
    scl = 1; wt(H);
    sda_m = 1; wt(H);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H);
      scl = 1; wt(H);
      scl = 0; wt(2);
    end
    sda_m = 1; wt(H);
    scl = 1; wt(H / 2);
    ack = !sda_line;
    wt(H / 2);
    scl = 0; wt(2);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) wt(1);
  endtask

  initial begin
    bit a;
    int n0, p0;
    logic [10:0] ea;
    wt(3);
    // R10
    chk(sda_oe == 0 && wr_en == 0 && busy == 0 && prog_start == 0, "R10 reset outputs",
        {sda_oe, wr_en, busy, prog_start}, 0);
    rst_n = 1; wt(5);
    chk(sda_oe == 0 && busy == 0, "R10 after release", {sda_oe, busy}, 0);

    bus_start();
    send(8'hA2, a); chk(a, "R1 select ack", a, 1);
    send(8'h23, a); chk(a, "R3 word address ack", a, 1);
    send(8'h7E, a); chk(a, "R4 data ack", a, 1);
    bus_stop(); wt(2);
    chk(nlog == 1, "R4 write count", nlog, 1);
    chk(la[0] == 11'h123, "R1 R3 write address", la[0], 11'h123);
    chk(ld[0] == 8'h7E, "R4 write data", ld[0], 8'h7E);
    chk(nprog == 1, "R6 prog pulse", nprog, 1);
    chk(busy == 1, "R6 busy after stop", busy, 1);

    bus_start();
    send(8'hA2, a); chk(!a, "R8 poll while busy", a, 0);
    send(8'h11, a); chk(!a, "R8 byte while busy", a, 0);
    bus_stop();
    chk(nlog == 1 && nprog == 1, "R8 no write or prog while busy", nlog, 1);
    wait_idle(); wt(2);
    chk(busy_cyc == PROG, "R6 busy length", busy_cyc, PROG);

    bus_start();
    send(8'hA0, a); chk(a, "R9 poll after done", a, 1);
    bus_stop(); wt(4);
    chk(nprog == 1 && busy == 0, "R7 stop after select only", nprog, 1);

    bus_start();
    send(8'hA0, a);
    send(8'h55, a); chk(a, "R3 ack", a, 1);
    bus_stop(); wt(4);
    chk(nprog == 1 && busy == 0 && nlog == 1, "R7 stop after word address", nprog, 1);

    bus_start();
    send(8'hB0, a); chk(!a, "R2 wrong code nack", a, 0);
    send(8'h00, a); chk(!a, "R2 later byte nack", a, 0);
    send(8'h99, a); chk(!a, "R2 data nack", a, 0);
    bus_stop(); wt(4);
    bus_start();
    send(8'hA1, a); chk(!a, "R2 read bit nack", a, 0);
    bus_stop(); wt(4);
    chk(nlog == 1 && nprog == 1 && busy == 0, "R2 no write no prog", nlog, 1);

    n0 = nlog;
    bus_start();
    send(8'hA4, a);
    send(8'hA5, a);
    for (int i = 0; i < 20; i++) begin
      send(8'h30 + 8'(i), a);
      chk(a, "R4 burst ack", a, 1);
    end
    bus_stop(); wt(2);
    chk(nlog - n0 == 20, "R4 burst count", nlog - n0, 20);
    for (int i = 0; i < 20; i++) begin
      ea = {3'd2, 4'hA, 4'((5 + i) % 16)};
      chk(la[n0 + i] == ea && ld[n0 + i] == 8'h30 + 8'(i), "R5 wrap address", la[n0 + i], ea);
    end
    chk(nprog == 2, "R6 burst prog", nprog, 2);
    wait_idle(); wt(2);

    for (int b = 0; b < 8; b++) begin
      n0 = nlog; p0 = nprog;
      bus_start();
      send({4'hA, 3'(b), 1'b0}, a); chk(a, "R1 block select ack", a, 1);
      send(8'h5A, a);
      send(8'(b) ^ 8'hC3, a);
      bus_stop(); wt(2);
      ea = {3'(b), 8'h5A};
      chk(nlog == n0 + 1 && la[n0] == ea, "R1 block address", la[n0], ea);
      chk(ld[n0] == (8'(b) ^ 8'hC3) && nprog == p0 + 1, "R4 block data", ld[n0], 8'(b) ^ 8'hC3);
      wait_idle(); wt(2);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule